// File: doc/BRIEF.md
# Bus Master Write Engine

This block lets a local processor issue writes on a 32-bit backplane bus without handling the bus protocol itself. The processor fills a set of latches through a small register-select write port: a control byte (address modifier code, the write line and the long-word line), the upper half of the target address, an optional upper-16-bit data word, and finally a start register that carries the lower address bits and the data word. The write to the start register launches the bus cycle.

The engine then raises its bus request at one fixed level and waits for the matching grant. Once it owns the bus it strobes address and data and waits for the slave's acknowledge. Without a hold request it gives the bus back at the acknowledge. With the hold request asserted it keeps ownership, so later writes start without arbitration. A block mode drives the address only on the first beat of a run. Grants at levels the engine does not want are passed down the daisy chain. Two status outputs report ownership and readiness for the next write.

Top module: `bus_write_master`

## Requirements
- R1: After reset no request is raised (`br_n` all ones), all strobes are high, both drive enables are low, `is_master` is 0, `done` is 1 and `bg_out_n` equals `bg_in_n`.
- R2: A write with `wr_sel` = 3 starts a cycle. From the next cycle `br_n` is low only at bit `REQ_LEVEL` (default 3, so `br_n` = 4'b0111), and it stays low until the engine releases the bus.
- R3: No strobe or drive enable is asserted before the grant. `is_master` rises on the edge at which `bg_in_n[REQ_LEVEL]` is seen low while the engine wants the bus. The strobes follow one cycle later.
- R4: `as_n`, `ds0_n` and `ds1_n` go low together and stay low while `dtack_n` is high. On the edge at which `dtack_n` is seen low they all return high and `done` returns to 1.
- R5: With `hold_req_n` high, mastership is dropped and the request is withdrawn on the acknowledge edge.
- R6: With `hold_req_n` low the request is raised even when no write is pending, and ownership is kept across transfers. A new write is strobed one cycle after it is loaded, with no new grant.
- R7: `wr_sel` = 1 loads `wr_data[15:0]` into address bits 31:16, and that value persists across transfers. Each start write loads `wr_lo` into address bits 15:1.
- R8: `wr_sel` = 0 loads the control byte. Bits 5:0 drive `bus_am`, bit 6 drives `bus_write_n` and bit 7 drives `bus_lword_n`.
- R9: A start with `wide32` = 0 drives `bus_data` = {8'hFF, data[23:0]}. A start with `wide32` = 1 drives `bus_data` = {upper latch, data[15:0]}, where the upper latch is loaded by `wr_sel` = 2 from `wr_data[15:0]`.
- R10: With `blk_mode` low, `addr_oe` and `data_oe` both assert during every strobe. With `blk_mode` high and ownership kept, only the first beat asserts `addr_oe`; later beats assert `data_oe` alone.
- R11: Grants at levels other than `REQ_LEVEL` pass through to `bg_out_n` unchanged. The grant at `REQ_LEVEL` passes through only while the engine neither wants nor owns the bus.
- R12: While a cycle is pending, `wr_stall` is 1 and every register write is ignored. The bus later shows the values loaded before the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe from the processor |
| wr_sel | input | 2 | Register select: 0 control, 1 high address, 2 upper data, 3 start |
| wr_lo | input | 15 | Address bits 15:1, taken on a start write |
| wr_data | input | 24 | Write data |
| wide32 | input | 1 | Word length for the started cycle: 1 selects 32-bit, 0 selects 24-bit |
| wr_stall | output | 1 | Cycle pending; writes are ignored |
| blk_mode | input | 1 | Block transfer mode |
| hold_req_n | input | 1 | Keep bus ownership, active low |
| br_n | output | 4 | Bus request lines, active low |
| bg_in_n | input | 4 | Incoming bus grants, active low |
| bg_out_n | output | 4 | Grant daisy-chain outputs, active low |
| dtack_n | input | 1 | Slave acknowledge, active low |
| as_n | output | 1 | Address strobe, active low |
| ds0_n | output | 1 | Data strobe 0, active low |
| ds1_n | output | 1 | Data strobe 1, active low |
| addr_oe | output | 1 | Address and modifier driver enable |
| data_oe | output | 1 | Data driver enable |
| bus_addr | output | 31 | Bus address bits 31:1 |
| bus_data | output | 32 | Bus data |
| bus_am | output | 6 | Address modifier code |
| bus_write_n | output | 1 | Write line value from the control byte |
| bus_lword_n | output | 1 | Long-word line value from the control byte |
| is_master | output | 1 | Engine currently owns the bus |
| done | output | 1 | No cycle pending; ready for the next write |

## Verification
The processor register port and the bus cycle can collide: a register write can land while a cycle is still pending and waiting for its grant. The bench issues a high-address write and a second start write in that window. It then judges the later strobe by whether the bus still shows the address and data loaded before the stall. The acknowledge edge and the hold request also meet: the acknowledge arrives while the hold is asserted, and the next write must be strobed without a grant and, in block mode, without address drive.

// File: rtl/bus_write_master.sv
module bus_write_master #(
  parameter int REQ_LEVEL = 3,
  parameter int LEVELS    = 4,
  parameter int HI_W      = 16,
  parameter int LO_W      = 15,
  parameter int DW        = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [LO_W-1:0]      wr_lo,
  input  logic [DW-1:0]        wr_data,
  input  logic                 wide32,
  output logic                 wr_stall,
  input  logic                 blk_mode,
  input  logic                 hold_req_n,
  output logic [LEVELS-1:0]    br_n,
  input  logic [LEVELS-1:0]    bg_in_n,
  output logic [LEVELS-1:0]    bg_out_n,
  input  logic                 dtack_n,
  output logic                 as_n,
  output logic                 ds0_n,
  output logic                 ds1_n,
  output logic                 addr_oe,
  output logic                 data_oe,
  output logic [HI_W+LO_W:1]   bus_addr,
  output logic [31:0]          bus_data,
  output logic [5:0]           bus_am,
  output logic                 bus_write_n,
  output logic                 bus_lword_n,
  output logic                 is_master,
  output logic                 done
);
  localparam int PAD = 32 - DW;
  localparam logic [1:0] SEL_CTRL = 2'd0, SEL_HI = 2'd1, SEL_UP = 2'd2, SEL_GO = 2'd3;

  logic [7:0]      ctrl_q;
  logic [HI_W-1:0] hi_q;
  logic [15:0]     up_q;
  logic [LO_W-1:0] lo_q;
  logic [DW-1:0]   dat_q;
  logic            wide_q, pending, owned, strobe, blk_first;

  wire accept = wr_en & ~pending;
  wire start  = accept & (wr_sel == SEL_GO);
  wire ack    = strobe & ~dtack_n;
  wire want   = pending | ~hold_req_n;
  wire grant  = ~bg_in_n[REQ_LEVEL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      hi_q      <= '0;
      up_q      <= '0;
      lo_q      <= '0;
      dat_q     <= '0;
      wide_q    <= 1'b0;
      pending   <= 1'b0;
      owned     <= 1'b0;
      strobe    <= 1'b0;
      blk_first <= 1'b1;
    end else begin
      if (accept) begin
        case (wr_sel)
          SEL_CTRL: ctrl_q <= wr_data[7:0];
          SEL_HI:   hi_q   <= wr_data[HI_W-1:0];
          SEL_UP:   up_q   <= wr_data[15:0];
          SEL_GO: begin
            lo_q   <= wr_lo;
            dat_q  <= wr_data;
            wide_q <= wide32;
          end
        endcase
      end
      pending   <= pending ? ~ack : start;
      owned     <= owned ? ((pending & ~ack) | ~hold_req_n) : (want & grant);
      strobe    <= strobe ? ~ack : (owned & pending);
      blk_first <= (~blk_mode | ~owned) ? 1'b1 : (ack ? 1'b0 : blk_first);
    end
  end

  for (genvar i = 0; i < LEVELS; i++) begin : g_lvl
    if (i == REQ_LEVEL) begin : g_own
      assign br_n[i]     = ~(want | owned);
      assign bg_out_n[i] = bg_in_n[i] | want | owned;
    end else begin : g_pass
      assign br_n[i]     = 1'b1;
      assign bg_out_n[i] = bg_in_n[i];
    end
  end

  assign as_n        = ~strobe;
  assign ds0_n       = ~strobe;
  assign ds1_n       = ~strobe;
  assign data_oe     = strobe;
  assign addr_oe     = strobe & (~blk_mode | blk_first);
  assign bus_addr    = {hi_q, lo_q};
  assign bus_data    = wide_q ? {up_q, dat_q[15:0]} : {{PAD{1'b1}}, dat_q};
  assign bus_am      = ctrl_q[5:0];
  assign bus_write_n = ctrl_q[6];
  assign bus_lword_n = ctrl_q[7];
  assign is_master   = owned;
  assign done        = ~pending;
  assign wr_stall    = pending;
endmodule

// File: rtl/bus_write_master_chk.sv
module bus_write_master_chk #(
  parameter int REQ_LEVEL = 3,
  parameter int LEVELS    = 4,
  parameter int AW        = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_stall,
  input logic              hold_req_n,
  input logic              dtack_n,
  input logic              as_n,
  input logic              is_master,
  input logic              done,
  input logic [LEVELS-1:0] bg_in_n,
  input logic [LEVELS-1:0] bg_out_n,
  input logic [AW:1]       bus_addr
);
  assert_strobe_owned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !as_n |-> is_master);

  assert_master_granted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(is_master) |-> $past(!bg_in_n[REQ_LEVEL]));

  assert_strobe_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && dtack_n) |=> !as_n);

  assert_ack_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && !dtack_n) |=> (as_n && done));

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && !dtack_n && hold_req_n) |=> !is_master);

  assert_grant_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    is_master |-> bg_out_n[REQ_LEVEL]);

  assert_stall_ignores_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_stall) |=> $stable(bus_addr));
endmodule

bind bus_write_master bus_write_master_chk #(
  .REQ_LEVEL(REQ_LEVEL), .LEVELS(LEVELS), .AW(HI_W + LO_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_stall(wr_stall),
  .hold_req_n(hold_req_n), .dtack_n(dtack_n), .as_n(as_n),
  .is_master(is_master), .done(done), .bg_in_n(bg_in_n),
  .bg_out_n(bg_out_n), .bus_addr(bus_addr)
);

// File: tb/bus_write_master_tb_top.sv
module bus_write_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [14:0] wr_lo = '0;
  logic [23:0] wr_data = '0;
  logic        wide32 = 1'b0;
  logic        blk_mode = 1'b0;
  logic        hold_req_n = 1'b1;
  logic [3:0]  bg_in_n = 4'hF;
  logic        dtack_n = 1'b1;
  logic        wr_stall, as_n, ds0_n, ds1_n, addr_oe, data_oe;
  logic        bus_write_n, bus_lword_n, is_master, done;
  logic [3:0]  br_n, bg_out_n;
  logic [31:1] bus_addr;
  logic [31:0] bus_data;
  logic [5:0]  bus_am;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  bus_write_master dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_lo(wr_lo),
    .wr_data(wr_data), .wide32(wide32), .wr_stall(wr_stall), .blk_mode(blk_mode),
    .hold_req_n(hold_req_n), .br_n(br_n), .bg_in_n(bg_in_n), .bg_out_n(bg_out_n),
    .dtack_n(dtack_n), .as_n(as_n), .ds0_n(ds0_n), .ds1_n(ds1_n),
    .addr_oe(addr_oe), .data_oe(data_oe), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_am(bus_am), .bus_write_n(bus_write_n), .bus_lword_n(bus_lword_n),
    .is_master(is_master), .done(done)
  );

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [15:0] hi;
    logic [15:0] up;
    logic [14:0] lo;
    logic [23:0] dat;
    logic        wide;
    logic [31:0] exp_data;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{8'h09, 16'h1A00, 16'hBEEF, 15'h0004, 24'h123456, 1'b0, 32'hFF123456},
    '{8'hB9, 16'h0000, 16'hCAFE, 15'h7FFF, 24'hAA5555, 1'b1, 32'hCAFE5555},
    '{8'h40, 16'hFFFF, 16'h0000, 15'h0000, 24'h000000, 1'b1, 32'h00000000},
    '{8'hFF, 16'h8001, 16'h1234, 15'h2AAA, 24'hFFFFFF, 1'b0, 32'hFFFFFFFF}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] s, input logic [14:0] lo, input logic [23:0] d, input logic w);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_lo = lo; wr_data = d; wide32 = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic acknowledge();
    dtack_n = 1'b0;
    @(negedge clk);
    dtack_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 br_n idle", 32'(br_n), 32'hF);
    chk("R1 strobes idle", 32'({as_n, ds0_n, ds1_n}), 32'h7);
    chk("R1 enables/status", 32'({addr_oe, data_oe, is_master, done}), 32'h1);
    chk("R1 grant chain", 32'(bg_out_n), 32'hF);

    for (int i = 0; i < 4; i++) begin
      vec_t v;
      v = VECS[i];
      wreg(2'd0, '0, {16'h0, v.ctrl}, 1'b0);
      wreg(2'd1, '0, {8'h0, v.hi}, 1'b0);
      wreg(2'd2, '0, {8'h0, v.up}, 1'b0);
      wreg(2'd3, v.lo, v.dat, v.wide);
      chk("R2 request level", 32'(br_n), 32'h7);
      chk("R3 nothing before grant", 32'({as_n, data_oe, is_master}), 32'h4);
      if (i == 0) begin
        chk("R12 stall while pending", 32'({wr_stall, done}), 32'h2);
        wreg(2'd1, '0, 24'h005A5A, 1'b0);
        wreg(2'd3, 15'h1111, 24'h999999, 1'b1);
        chk("R2 request held", 32'(br_n), 32'h7);
      end
      bg_in_n = 4'b0110;
      #1;
      chk("R11 grant chain", 32'(bg_out_n), 32'hE);
      @(negedge clk);
      chk("R3 master after grant", 32'({is_master, as_n}), 32'h3);
      @(negedge clk);
      chk("R4 strobes low", 32'({as_n, ds0_n, ds1_n}), 32'h0);
      chk("R7 R12 address", 32'({bus_addr, 1'b0}), {v.hi, v.lo, 1'b0});
      chk("R9 R12 data", bus_data, v.exp_data);
      chk("R8 control byte", 32'({bus_lword_n, bus_write_n, bus_am}), 32'(v.ctrl));
      chk("R10 both enables", 32'({addr_oe, data_oe}), 32'h3);
      if (i == 1) begin
        repeat (2) @(negedge clk);
        chk("R4 strobe held w/o ack", 32'({as_n, done}), 32'h0);
      end
      acknowledge();
      bg_in_n = 4'hF;
      chk("R4 cycle ended", 32'({as_n, ds0_n, ds1_n, done}), 32'hF);
      chk("R5 released", 32'({br_n, is_master}), 32'h1E);
    end

    hold_req_n = 1'b0;
    #1;
    chk("R6 hold request idle", 32'(br_n), 32'h7);
    bg_in_n = 4'b0111;
    @(negedge clk);
    chk("R6 master via hold", 32'(is_master), 32'h1);
    bg_in_n = 4'hF;
    blk_mode = 1'b1;
    wreg(2'd1, '0, 24'h00CAFE, 1'b0);
    wreg(2'd3, 15'h0010, 24'h000001, 1'b0);
    @(negedge clk);
    chk("R6 strobe without regrant", 32'(as_n), 32'h0);
    chk("R10 first beat address", 32'({addr_oe, data_oe}), 32'h3);
    chk("R7 new high address", 32'({bus_addr, 1'b0}), {16'hCAFE, 15'h0010, 1'b0});
    acknowledge();
    chk("R6 kept after ack", 32'({is_master, done}), 32'h3);
    wreg(2'd3, 15'h0011, 24'h000002, 1'b0);
    @(negedge clk);
    chk("R10 later beat data only", 32'({addr_oe, data_oe, as_n}), 32'h2);
    chk("R7 high address persists", 32'({bus_addr, 1'b0}), {16'hCAFE, 15'h0011, 1'b0});
    chk("R9 narrow data", bus_data, 32'hFF000002);
    acknowledge();
    blk_mode = 1'b0;
    hold_req_n = 1'b1;
    @(negedge clk);
    chk("R5 release after hold", 32'({br_n, is_master}), 32'h1E);
    finish_run();
  end
endmodule